// File: doc/BRIEF.md
# Two-Wire Indexed Configuration Register Slave

This block is a slave on an SMBus-style two-wire bus. It gives a host access to a bank of twenty 8-bit configuration registers through indexed block transfers. Every transfer opens with a starting register index. A write then carries a byte count and the data bytes, which go to consecutive registers. A read switches direction with a repeated start. The slave answers first with the contents of its programmable count register and then with register data from the index upward.

SCL and SDA come in as sampled open-drain line levels. The slave pulls SDA low through a single enable output, both to acknowledge and to send zero bits. It never stretches the clock. On the core side the whole register bank is exposed as a flat vector. Two read-only fields are supplied from inputs: a 4-bit vendor identifier and a 2-bit alarm status.

Top module: `smb_regbank`

## Requirements
- R1: The slave acknowledges address byte 0xD2 (write) and 0xD3 (read), which is 7-bit address 0x69 with the direction bit in bit 0. Any other address byte gets no acknowledge, and the slave ignores the bus until the next start.
- R2: A write sends the index N, then a count X, then data bytes. Data bytes are stored to registers N, N+1, and so on, and the slave acknowledges every byte.
- R3: Data bytes sent after X bytes of a write have been stored are acknowledged but stored nowhere.
- R4: After a repeated start with 0xD3, the slave first sends the value of register 8 and then sends the registers from index N upward. It sends the most significant bit first.
- R5: The slave releases SDA after the host answers a read byte with a not-acknowledge, and it stays released until the next start.
- R6: After reset, register 0 reads 0x40, register 1 reads 0xFE, register 2 reads 0xFF, register 3 reads 0x7F, register 4 reads 0x0F, register 6 reads 0xFF and register 9 reads 0x07. Registers 5 and 10 to 19 read 0x00.
- R7: Register 7 bits 3:0 always read `vendor_id_i`, and register 9 bits 5:4 always read `alarm_i`. Writes to these bits have no effect. The other bits of registers 7 and 9 are writable.
- R8: Register 8 resets to 0x0F and is writable. The count byte a read returns is its current value.
- R9: An index of 20 or more reads as 0x00. A write to such an index is acknowledged and discarded, and auto-increment carries on across the end of the bank.
- R10: A start or stop condition that arrives before the eighth bit of a byte completes aborts the transfer. The partial byte is not committed.
- R11: `cfg_o` byte k (bits 8k+7:8k) equals what a bus read of register k returns.
- R12: The slave changes its SDA drive only while SCL is low, so it never creates a start or stop condition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, samples the bus lines |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Sampled SCL line level |
| sda_i | input | 1 | Sampled SDA line level |
| sda_oe_o | output | 1 | Pull SDA low when 1 |
| vendor_id_i | input | 4 | Read-only identifier shown in register 7 bits 3:0 |
| alarm_i | input | 2 | Read-only status shown in register 9 bits 5:4 |
| cfg_o | output | 160 | Register bank contents, register k in bits 8k+7:8k |

## Verification
Each line passes through two synchronizer flops and one edge-detect flop, so the control registers react on the third clock after an SCL edge. An acknowledge or data bit therefore appears on SDA three to four clocks after SCL falls. The bench holds each SCL phase for eight clocks and reads SDA in the middle of the high phase, well after the slave's drive has settled. A stored byte reaches `cfg_o` a few clocks after the ninth-bit falling edge. The bench reads `cfg_o` and checks the drive enable only once a whole frame or bit slot has closed, so no check samples inside the pipeline's latency.

// File: rtl/smb_pkg.sv
package smb_pkg;

    localparam int DW      = 8;
    localparam int REG_VID = 7;
    localparam int REG_CNT = 8;
    localparam int REG_WDT = 9;

    typedef enum logic [2:0] {
        ST_IDLE, ST_RX, ST_RXACK, ST_TX, ST_TXACK, ST_IGNORE
    } st_e;

    typedef enum logic [1:0] {
        PH_ADDR, PH_INDEX, PH_COUNT, PH_DATA
    } ph_e;

    typedef struct packed {
        st_e        st;
        ph_e        ph;
        logic [3:0] cnt;
        logic [7:0] sh;
        logic [7:0] ptr;
        logic [7:0] left;
        logic       rd;
        logic       oe;
    } ctl_t;

    function automatic logic [DW-1:0] reset_value(int idx);
        case (idx)
            0:       return 8'h40;
            1:       return 8'hFE;
            2:       return 8'hFF;
            3:       return 8'h7F;
            4:       return 8'h0F;
            6:       return 8'hFF;
            REG_CNT: return 8'h0F;
            REG_WDT: return 8'h07;
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic [DW-1:0] ro_mask(int idx);
        case (idx)
            REG_VID: return 8'h0F;
            REG_WDT: return 8'h30;
            default: return 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_ev,
    output logic stop_ev
);
    logic [STAGES-1:0] scl_ff, sda_ff;
    logic              scl_p, sda_p;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_ff <= '1;
            sda_ff <= '1;
            scl_p  <= 1'b1;
            sda_p  <= 1'b1;
        end else begin
            scl_ff <= {scl_ff[STAGES-2:0], scl_i};
            sda_ff <= {sda_ff[STAGES-2:0], sda_i};
            scl_p  <= scl_ff[STAGES-1];
            sda_p  <= sda_ff[STAGES-1];
        end
    end

    assign scl_s    = scl_ff[STAGES-1];
    assign sda_s    = sda_ff[STAGES-1];
    assign scl_rise = scl_s & ~scl_p;
    assign scl_fall = ~scl_s & scl_p;
    assign start_ev = scl_s & scl_p & sda_p & ~sda_s;
    assign stop_ev  = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/smb_regfile.sv
module smb_regfile
    import smb_pkg::*;
#(
    parameter int NREG = 20
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [7:0]         wr_idx,
    input  logic [DW-1:0]      wr_data,
    input  logic [7:0]         rd_idx,
    input  logic [3:0]         vendor_id_i,
    input  logic [1:0]         alarm_i,
    output logic [DW-1:0]      rd_data,
    output logic [NREG*DW-1:0] cfg_o
);
    logic [DW-1:0] view [NREG];

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        localparam logic [DW-1:0] RV = reset_value(i);
        localparam logic [DW-1:0] RO = ro_mask(i);
        logic [DW-1:0] q;
        logic [DW-1:0] ro_v;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                            q <= RV & ~RO;
            else if (wr_en && wr_idx == 8'(i))     q <= wr_data & ~RO;
        end

        if (i == REG_VID) begin : g_vid
            assign ro_v = {4'h0, vendor_id_i};
        end else if (i == REG_WDT) begin : g_alarm
            assign ro_v = {2'b00, alarm_i, 4'h0};
        end else begin : g_none
            assign ro_v = '0;
        end

        assign view[i]            = q | ro_v;
        assign cfg_o[i*DW +: DW]  = view[i];
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NREG; i++) begin
            if (rd_idx == 8'(i)) rd_data = view[i];
        end
    end
endmodule

// File: rtl/smb_regbank.sv
module smb_regbank
    import smb_pkg::*;
#(
    parameter int         NREG        = 20,
    parameter int         SYNC_STAGES = 2,
    parameter logic [6:0] SLV_ADDR    = 7'h69
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_i,
    input  logic               sda_i,
    output logic               sda_oe_o,
    input  logic [3:0]         vendor_id_i,
    input  logic [1:0]         alarm_i,
    output logic [NREG*DW-1:0] cfg_o
);
    localparam logic [7:0] NREG_B = 8'(NREG);

    logic          scl_s, sda_s, scl_rise, scl_fall, start_ev, stop_ev;
    logic          wr_en;
    logic [7:0]    wr_idx;
    logic [DW-1:0] wr_data, rd_data, cnt_reg;
    ctl_t          ctl_d, ctl_q;

    smb_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_ev(start_ev), .stop_ev(stop_ev)
    );

    smb_regfile #(.NREG(NREG)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_data(wr_data), .rd_idx(ctl_q.ptr), .vendor_id_i(vendor_id_i),
        .alarm_i(alarm_i), .rd_data(rd_data), .cfg_o(cfg_o)
    );

    assign cnt_reg = cfg_o[REG_CNT*DW +: DW];

    always_comb begin
        ctl_d   = ctl_q;
        wr_en   = 1'b0;
        wr_idx  = ctl_q.ptr;
        wr_data = ctl_q.sh;
        if (stop_ev) begin
            ctl_d.st = ST_IDLE;
            ctl_d.oe = 1'b0;
        end else if (start_ev) begin
            ctl_d.st  = ST_RX;
            ctl_d.ph  = PH_ADDR;
            ctl_d.cnt = 4'd0;
            ctl_d.oe  = 1'b0;
        end else begin
            case (ctl_q.st)
                ST_RX: begin
                    if (scl_rise && ctl_q.cnt != 4'd8) begin
                        ctl_d.sh  = {ctl_q.sh[6:0], sda_s};
                        ctl_d.cnt = ctl_q.cnt + 4'd1;
                    end else if (scl_fall && ctl_q.cnt == 4'd8) begin
                        ctl_d.cnt = 4'd0;
                        ctl_d.st  = ST_RXACK;
                        ctl_d.oe  = 1'b1;
                        case (ctl_q.ph)
                            PH_ADDR: begin
                                if (ctl_q.sh[7:1] == SLV_ADDR) begin
                                    ctl_d.rd = ctl_q.sh[0];
                                    ctl_d.ph = PH_INDEX;
                                end else begin
                                    ctl_d.st = ST_IGNORE;
                                    ctl_d.oe = 1'b0;
                                end
                            end
                            PH_INDEX: begin
                                ctl_d.ptr = ctl_q.sh;
                                ctl_d.ph  = PH_COUNT;
                            end
                            PH_COUNT: begin
                                ctl_d.left = ctl_q.sh;
                                ctl_d.ph   = PH_DATA;
                            end
                            default: begin
                                if (ctl_q.left != 8'd0) begin
                                    wr_en      = (ctl_q.ptr < NREG_B);
                                    ctl_d.ptr  = ctl_q.ptr + 8'd1;
                                    ctl_d.left = ctl_q.left - 8'd1;
                                end
                            end
                        endcase
                    end
                end
                ST_RXACK: begin
                    if (scl_fall) begin
                        ctl_d.cnt = 4'd0;
                        if (ctl_q.rd && ctl_q.ph == PH_INDEX) begin
                            ctl_d.st = ST_TX;
                            ctl_d.ph = PH_DATA;
                            ctl_d.sh = cnt_reg;
                            ctl_d.oe = ~cnt_reg[7];
                        end else begin
                            ctl_d.st = ST_RX;
                            ctl_d.oe = 1'b0;
                        end
                    end
                end
                ST_TX: begin
                    if (scl_fall) begin
                        if (ctl_q.cnt == 4'd7) begin
                            ctl_d.st = ST_TXACK;
                            ctl_d.oe = 1'b0;
                        end else begin
                            ctl_d.sh  = {ctl_q.sh[6:0], 1'b0};
                            ctl_d.oe  = ~ctl_q.sh[6];
                            ctl_d.cnt = ctl_q.cnt + 4'd1;
                        end
                    end
                end
                ST_TXACK: begin
                    if (scl_rise && sda_s) begin
                        ctl_d.st = ST_IGNORE;
                    end else if (scl_fall) begin
                        ctl_d.st  = ST_TX;
                        ctl_d.cnt = 4'd0;
                        ctl_d.sh  = rd_data;
                        ctl_d.oe  = ~rd_data[7];
                        ctl_d.ptr = ctl_q.ptr + 8'd1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{st: ST_IDLE, ph: PH_ADDR, cnt: 4'd0, sh: 8'd0,
                       ptr: 8'd0, left: 8'd0, rd: 1'b0, oe: 1'b0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign sda_oe_o = ctl_q.oe;
endmodule

// File: rtl/smb_regbank_chk.sv
module smb_regbank_chk
    import smb_pkg::*;
#(
    parameter int NREG = 20
) (
    input logic               clk,
    input logic               rst_n,
    input logic               scl_s,
    input logic               sda_oe,
    input logic               wr_en,
    input logic [7:0]         wr_idx,
    input st_e                st,
    input logic               stop_ev,
    input logic [3:0]         vendor_id_i,
    input logic [NREG*DW-1:0] cfg_o
);
    p_sda_quiet_scl_high_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_s && $past(scl_s)) |-> $stable(sda_oe));

    p_ignore_released_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IGNORE) |-> !sda_oe);

    p_write_in_bank_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_idx < 8'(NREG)));

    p_stop_to_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        stop_ev |=> (st == ST_IDLE));

    p_vendor_view_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_o[REG_VID*DW +: 4] == vendor_id_i);
endmodule

bind smb_regbank smb_regbank_chk #(.NREG(NREG)) u_chk (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_oe(sda_oe_o),
    .wr_en(wr_en), .wr_idx(wr_idx), .st(ctl_q.st), .stop_ev(stop_ev),
    .vendor_id_i(vendor_id_i), .cfg_o(cfg_o)
);

// File: tb/smb_regbank_bench.sv
module smb_regbank_bench;
    localparam int NREG = 20;
    localparam int Q    = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              scl_drv = 1'b1;
    logic              sda_low = 1'b0;
    logic              sda_oe;
    logic [3:0]        vid = 4'h1;
    logic [1:0]        alarm = 2'b00;
    logic [NREG*8-1:0] cfg;
    wire               sda_bus = ~(sda_low | sda_oe);

    int   n_run = 0, n_fail = 0, wd = 0;
    logic done = 1'b0;
    logic ack_ok, a;
    logic [7:0] cntb, tmp;
    logic [7:0] wbuf [16];
    logic [7:0] rbuf [16];

    // {index, written byte, expected read-back}
    localparam logic [23:0] VEC [8] = '{
        24'h02A5A5,  // R2 plain register
        24'h07FFF1,  // R7 vendor nibble read-only
        24'h09FFCF,  // R7 alarm bits read-only
        24'h133C3C,  // R2 last register
        24'h145500,  // R9 first index past the bank
        24'h001212,  // R2 register 0
        24'h058181,  // R2 register 5
        24'hFFAA00   // R9 far index
    };

    always #10 clk = ~clk;

    smb_regbank u_smb_regbank (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_drv), .sda_i(sda_bus),
        .sda_oe_o(sda_oe), .vendor_id_i(vid), .alarm_i(alarm), .cfg_o(cfg)
    );

    always @(posedge clk) begin
        wd <= wd + 1;
        if (wd == 150000 && !done) begin
            n_fail = n_fail + 1;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    task automatic w(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        n_run = n_run + 1;
        if (got !== exp) begin
            n_fail = n_fail + 1;
            $display("FAIL %s got %02h exp %02h", tag, got, exp);
        end
    endtask

    task automatic h_start();
        scl_drv = 1'b0; w(Q);
        sda_low = 1'b0; w(Q);
        scl_drv = 1'b1; w(Q);
        sda_low = 1'b1; w(Q);
        scl_drv = 1'b0; w(Q);
    endtask

    task automatic h_stop();
        scl_drv = 1'b0; sda_low = 1'b1; w(Q);
        scl_drv = 1'b1; w(Q);
        sda_low = 1'b0; w(Q);
    endtask

    task automatic h_bit(input logic b);
        sda_low = ~b; w(Q);
        scl_drv = 1'b1; w(2*Q);
        scl_drv = 1'b0; w(Q);
    endtask

    task automatic h_wbyte(input logic [7:0] b, output logic nack);
        for (int i = 7; i >= 0; i--) h_bit(b[i]);
        sda_low = 1'b0; w(Q);
        scl_drv = 1'b1; w(Q);
        nack = sda_bus; w(Q);
        scl_drv = 1'b0; w(Q);
    endtask

    task automatic h_rbyte(input logic nack, output logic [7:0] b);
        sda_low = 1'b0;
        for (int i = 7; i >= 0; i--) begin
            w(Q); scl_drv = 1'b1; w(Q); b[i] = sda_bus; w(Q); scl_drv = 1'b0;
        end
        w(1);
        sda_low = ~nack; w(Q);
        scl_drv = 1'b1; w(2*Q);
        scl_drv = 1'b0; w(Q);
        sda_low = 1'b0;
    endtask

    task automatic wr(input logic [7:0] idx, input logic [7:0] cnt, input int n);
        ack_ok = 1'b1;
        h_start();
        h_wbyte(8'hD2, a); ack_ok &= ~a;
        h_wbyte(idx, a);   ack_ok &= ~a;
        h_wbyte(cnt, a);   ack_ok &= ~a;
        for (int i = 0; i < n; i++) begin h_wbyte(wbuf[i], a); ack_ok &= ~a; end
        h_stop();
    endtask

    task automatic rd(input logic [7:0] idx, input int n);
        ack_ok = 1'b1;
        h_start();
        h_wbyte(8'hD2, a); ack_ok &= ~a;
        h_wbyte(idx, a);   ack_ok &= ~a;
        h_start();
        h_wbyte(8'hD3, a); ack_ok &= ~a;
        h_rbyte(n == 0, cntb);
        for (int i = 0; i < n; i++) h_rbyte(i == n - 1, rbuf[i]);
        w(Q);
        chk("R5 drive released after host NACK", {7'd0, sda_oe}, 8'h00);
        h_stop();
    endtask

    initial begin
        w(5); rst_n = 1'b1; w(5);

        // R8/R11 reset state at the core port
        chk("R8 cfg_o count reset", cfg[8*8 +: 8], 8'h0F);
        chk("R11 cfg_o reg1 reset", cfg[1*8 +: 8], 8'hFE);

        // R6/R4 reset values over the bus
        rd(8'd0, 10);
        chk("R1 read acks", {7'd0, ack_ok}, 8'h01);
        chk("R4 count byte first", cntb, 8'h0F);
        chk("R6 reg0", rbuf[0], 8'h40);
        chk("R6 reg1", rbuf[1], 8'hFE);
        chk("R6 reg3", rbuf[3], 8'h7F);
        chk("R6 reg4", rbuf[4], 8'h0F);
        chk("R6 reg6", rbuf[6], 8'hFF);
        chk("R7 vendor id reg7", rbuf[7], 8'h01);
        chk("R6 reg9", rbuf[9], 8'h07);

        // table walk: single-byte write then read back
        for (int v = 0; v < 8; v++) begin
            wbuf[0] = VEC[v][15:8];
            wr(VEC[v][23:16], 8'd1, 1);
            chk("R2/R9 table write acks", {7'd0, ack_ok}, 8'h01);
            rd(VEC[v][23:16], 1);
            chk("R2/R7/R9 table read-back", rbuf[0], VEC[v][7:0]);
        end
        chk("R11 cfg_o after table", cfg[2*8 +: 8], 8'hA5);

        // R2 auto-increment block
        wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33;
        wr(8'd10, 8'd3, 3);
        rd(8'd10, 3);
        chk("R2 block byte0", rbuf[0], 8'h11);
        chk("R2 block byte1", rbuf[1], 8'h22);
        chk("R2 block byte2", rbuf[2], 8'h33);

        // R3 bytes beyond count
        wbuf[0] = 8'h5A; wbuf[1] = 8'h6B;
        wr(8'd12, 8'd1, 2);
        chk("R3 extra byte acked", {7'd0, ack_ok}, 8'h01);
        chk("R3 counted byte stored", cfg[12*8 +: 8], 8'h5A);
        chk("R3 extra byte discarded", cfg[13*8 +: 8], 8'h00);

        // R9 crossing the end of the bank
        wbuf[0] = 8'hAB; wbuf[1] = 8'hCD; wbuf[2] = 8'hEF;
        wr(8'd18, 8'd3, 3);
        chk("R9 acks past bank", {7'd0, ack_ok}, 8'h01);
        rd(8'd18, 3);
        chk("R9 reg18", rbuf[0], 8'hAB);
        chk("R9 reg19", rbuf[1], 8'hCD);
        chk("R9 past end reads zero", rbuf[2], 8'h00);

        // R1 foreign address ignored
        h_start();
        h_wbyte(8'hA0, a);
        chk("R1 foreign address not acked", {7'd0, a}, 8'h01);
        h_wbyte(8'h02, a); h_wbyte(8'h01, a); h_wbyte(8'h77, a);
        h_stop();
        chk("R1 foreign write no effect", cfg[2*8 +: 8], 8'hA5);

        // R10 stop mid-byte
        h_start();
        h_wbyte(8'hD2, a); h_wbyte(8'd3, a); h_wbyte(8'd1, a);
        for (int i = 0; i < 4; i++) h_bit(1'b0);
        h_stop();
        chk("R10 stop mid-byte no commit", cfg[3*8 +: 8], 8'h7F);

        // R10 start mid-byte
        h_start();
        h_wbyte(8'hD2, a); h_wbyte(8'd4, a); h_wbyte(8'd1, a);
        for (int i = 0; i < 3; i++) h_bit(1'b1);
        h_start();
        h_stop();
        chk("R10 start mid-byte no commit", cfg[4*8 +: 8], 8'h0F);

        // R8 programmable count
        wbuf[0] = 8'h02;
        wr(8'd8, 8'd1, 1);
        rd(8'd0, 0);
        chk("R8 count byte follows register", cntb, 8'h02);

        // R7 live status input
        alarm = 2'b10;
        rd(8'd9, 1);
        chk("R7 alarm bits from input", rbuf[0], 8'hEF);
        chk("R11 cfg_o alarm view", cfg[9*8 +: 8], 8'hEF);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule